// File: doc/BRIEF.md
# Conditional Jump Target Unit

This block sits next to the program counter of a small 16-bit processor core. It looks at an instruction word and decides whether it belongs to the relative-branch format. If it does, the block evaluates one of eight branch conditions against the zero, carry, negative and overflow flags. It also forms the branch destination: the current program counter, which already points past the instruction, plus twice a sign-extended 10-bit word displacement. The decode outputs are combinational and follow the inputs directly.

Any branch that is issued occupies a fixed two-cycle slot, whether it is taken or not. A small sequencer captures the decision and the two candidate addresses when the branch is accepted. In the second cycle of the slot it presents the next program counter. It pulses the load strobe only when the branch is taken. The instruction fetch path and the ALU that produces the flags lie outside this block.

Top module: `jump_target_unit`

## Requirements
- R1: `is_jump_o` is 1 exactly when bits 15:13 of `instr_i` equal 3'b001, for all eight values of those bits.
- R2: With a branch word, `taken_o` follows the condition field in bits 12:10. 3'b000 means Z==0, 3'b001 means Z==1, 3'b010 means C==0, 3'b011 means C==1 and 3'b100 means N==1.
- R3: Condition 3'b101 is taken when N equals V. 3'b110 is taken when N differs from V. 3'b111 is always taken. A word that is not a branch never shows `taken_o`=1.
- R4: `target_o` equals `pc_i` with bit 0 cleared, plus two times bits 9:0 of `instr_i` read as a two's-complement value, modulo 2^16. Bit 0 of the result is always 0.
- R5: When `issue_i` is high with a branch word while the unit is idle, `busy_o` is high for exactly the two cycles after that clock edge. `done_o` is high only in the second of those two cycles, whatever the condition outcome.
- R6: In the cycle where `done_o` is high, `pc_load_o` is 1 and `pc_next_o` equals the captured target if the branch was taken. Otherwise `pc_load_o` is 0 and `pc_next_o` equals the captured `pc_i`.
- R7: Issuing a word that is not a branch starts no slot. `busy_o`, `done_o` and `pc_load_o` stay 0.
- R8: `issue_i` is ignored while `busy_o` is high. The slot in progress keeps its captured result and does not lengthen.
- R9: While `rst_n` is low, `busy_o`, `done_o` and `pc_load_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Instruction word is presented for execution |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter already past the instruction |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| is_jump_o | output | 1 | Word is in branch format (combinational) |
| taken_o | output | 1 | Branch condition holds (combinational) |
| target_o | output | 16 | Branch destination (combinational) |
| busy_o | output | 1 | Two-cycle branch slot in progress |
| done_o | output | 1 | Second cycle of the slot |
| pc_load_o | output | 1 | Load strobe for the program counter |
| pc_next_o | output | 16 | Next program counter value, valid with done_o |

## Verification
`is_jump_o`, `taken_o` and `target_o` are combinational, so they are due in the same cycle as their inputs. The bench drives these inputs after a falling edge and samples them a nanosecond later, with no clock edge in between. The slot outputs are registered. `busy_o` rises one edge after the issuing edge. `done_o`, `pc_load_o` and `pc_next_o` are due one edge after that. The bench therefore samples at the falling edge of each of those two cycles and once more after the slot, to confirm that the slot has ended.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  // Branch condition selector, bits 12:10 of the instruction word.
  typedef enum logic [2:0] {
    CC_NOT_ZERO  = 3'b000,
    CC_ZERO      = 3'b001,
    CC_NO_CARRY  = 3'b010,
    CC_CARRY     = 3'b011,
    CC_NEGATIVE  = 3'b100,
    CC_SIGNED_GE = 3'b101,
    CC_SIGNED_LT = 3'b110,
    CC_ALWAYS    = 3'b111
  } jtu_cond_e;

  // Sequencer state of the two-cycle branch slot.
  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_EXEC = 2'b01,
    SQ_LOAD = 2'b10
  } jtu_seq_e;

  typedef struct packed {
    logic n;
    logic v;
    logic c;
    logic z;
  } jtu_flags_t;

endpackage

// File: rtl/jtu_decode.sv
module jtu_decode #(
  parameter int INSTR_W  = 16,
  parameter int OPC_W    = 3,
  parameter int COND_W   = 3,
  parameter int OFS_W    = 10,
  parameter logic [OPC_W-1:0] JUMP_OPC = 3'b001
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  jtu_pkg::jtu_flags_t flags_i,
  output logic               is_jump_o,
  output logic               cond_ok_o,
  output logic [OFS_W-1:0]   offset_o
);
  import jtu_pkg::*;

  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int COND_LSB = OFS_W;

  logic [OPC_W-1:0]  opc_field;
  logic [COND_W-1:0] cond_field;
  jtu_cond_e         cond;

  assign opc_field  = instr_i[INSTR_W-1:OPC_LSB];
  assign cond_field = instr_i[COND_LSB+COND_W-1:COND_LSB];
  assign offset_o   = instr_i[OFS_W-1:0];
  assign cond       = jtu_cond_e'(cond_field);

  assign is_jump_o  = (opc_field == JUMP_OPC);

  always_comb begin
    cond_ok_o = 1'b0;
    unique case (cond)
      CC_NOT_ZERO:  cond_ok_o = ~flags_i.z;
      CC_ZERO:      cond_ok_o =  flags_i.z;
      CC_NO_CARRY:  cond_ok_o = ~flags_i.c;
      CC_CARRY:     cond_ok_o =  flags_i.c;
      CC_NEGATIVE:  cond_ok_o =  flags_i.n;
      CC_SIGNED_GE: cond_ok_o = ~(flags_i.n ^ flags_i.v);
      CC_SIGNED_LT: cond_ok_o =  (flags_i.n ^ flags_i.v);
      CC_ALWAYS:    cond_ok_o = 1'b1;
      default:      cond_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/jtu_target.sv
module jtu_target #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o
);
  // Word displacement becomes a byte displacement: one extra low zero bit.
  localparam int EXT_W = ADDR_W - OFS_W - 1;

  logic [ADDR_W-1:0] disp_bytes;
  logic [ADDR_W-1:0] pc_even;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_bytes = {{EXT_W{offset_i[OFS_W-1]}}, offset_i, 1'b0};
    end else begin : g_trunc
      assign disp_bytes = {offset_i[ADDR_W-2:0], 1'b0};
    end
  endgenerate

  assign pc_even  = {pc_i[ADDR_W-1:1], 1'b0};
  assign target_o = pc_even + disp_bytes;

endmodule

// File: rtl/jtu_seq.sv
module jtu_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_next_o
);
  import jtu_pkg::*;

  jtu_seq_e          state_q, state_d;
  logic              accept;
  logic              taken_q;
  logic [ADDR_W-1:0] target_q;
  logic [ADDR_W-1:0] seqpc_q;

  assign accept = start_i && (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (accept) state_d = SQ_EXEC;
      SQ_EXEC: state_d = SQ_LOAD;
      SQ_LOAD: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // Capture registers, loaded only on the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      target_q <= '0;
      seqpc_q  <= '0;
    end else if (accept) begin
      taken_q  <= taken_i;
      target_q <= target_i;
      seqpc_q  <= pc_i;
    end
  end

  assign busy_o    = (state_q != SQ_IDLE);
  assign done_o    = (state_q == SQ_LOAD);
  assign pc_load_o = done_o && taken_q;
  assign pc_next_o = taken_q ? target_q : seqpc_q;

  AST_EXEC_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_EXEC) |=> (state_q == SQ_LOAD)); // R5
  AST_LOAD_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_LOAD) |=> (state_q == SQ_IDLE)); // R5
  AST_STROBE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> done_o); // R6
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(target_q) && $stable(seqpc_q) && $stable(taken_q))); // R8

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 16,
  parameter int OFS_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               flag_z_i,
  input  logic               flag_c_i,
  input  logic               flag_n_i,
  input  logic               flag_v_i,
  output logic               is_jump_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  target_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               pc_load_o,
  output logic [ADDR_W-1:0]  pc_next_o
);
  import jtu_pkg::*;

  localparam int OPC_W  = 3;
  localparam int COND_W = 3;
  localparam int SYNC_W = 2;

  // Reset asserts at once and is released through a short flop chain.
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  jtu_flags_t       flags;
  logic             cond_ok;
  logic [OFS_W-1:0] offset;

  assign flags = '{n: flag_n_i, v: flag_v_i, c: flag_c_i, z: flag_z_i};

  jtu_decode #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .COND_W  (COND_W),
    .OFS_W   (OFS_W),
    .JUMP_OPC(3'b001)
  ) decode_i (
    .instr_i  (instr_i),
    .flags_i  (flags),
    .is_jump_o(is_jump_o),
    .cond_ok_o(cond_ok),
    .offset_o (offset)
  );

  jtu_target #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W)
  ) target_i (
    .pc_i    (pc_i),
    .offset_i(offset),
    .target_o(target_o)
  );

  assign taken_o = is_jump_o && cond_ok;

  jtu_seq #(
    .ADDR_W(ADDR_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (issue_i && is_jump_o),
    .taken_i  (taken_o),
    .target_i (target_o),
    .pc_i     (pc_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pc_load_o(pc_load_o),
    .pc_next_o(pc_next_o)
  );

  AST_NONJUMP_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && issue_i && !is_jump_o) |=> !busy_o); // R7
  AST_TAKEN_NEEDS_JUMP: assert property (@(posedge clk) disable iff (!rst_int_n)
    taken_o |-> is_jump_o); // R3
  AST_ISSUE_STARTS_SLOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && issue_i && is_jump_o) |=> (busy_o && !done_o)); // R5
  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    is_jump_o |-> (target_o[0] == 1'b0)); // R4

endmodule

// File: tb/jump_target_unit_tb.sv
`timescale 1ns/1ps
module jump_target_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [15:0] instr_i;
  logic [15:0] pc_i;
  logic        fz, fc, fn, fv;
  logic        is_jump_o, taken_o, busy_o, done_o, pc_load_o;
  logic [15:0] target_o, pc_next_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  jump_target_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i), .pc_i(pc_i),
    .flag_z_i(fz), .flag_c_i(fc), .flag_n_i(fn), .flag_v_i(fv),
    .is_jump_o(is_jump_o), .taken_o(taken_o), .target_o(target_o),
    .busy_o(busy_o), .done_o(done_o), .pc_load_o(pc_load_o), .pc_next_o(pc_next_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_cond(input int c, input logic z, input logic cy,
                                    input logic n, input logic v);
    case (c)
      0: return !z;
      1: return z;
      2: return !cy;
      3: return cy;
      4: return n;
      5: return n == v;
      6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_target(input logic [15:0] pc, input int off);
    int so;
    so = (off >= 512) ? off - 1024 : off;
    return 16'((int'(pc) & 32'hFFFE) + so * 2);
  endfunction

  // Issue one branch and check the two-cycle slot.
  task automatic run_slot(input int c, input int off, input logic [15:0] pc, input logic [3:0] fl);
    logic exp_t;
    @(negedge clk);
    instr_i = {3'b001, 3'(c), 10'(off)};
    pc_i = pc;
    {fn, fv, fc, fz} = fl;
    issue_i = 1'b1;
    exp_t = exp_cond(c, fl[0], fl[1], fl[3], fl[2]);
    @(negedge clk);
    issue_i = 1'b0;
    instr_i = 16'h0000;
    pc_i = ~pc;
    chk("R5 busy first", {31'd0, busy_o}, 1);
    chk("R5 done first", {31'd0, done_o}, 0);
    chk("R6 no strobe first", {31'd0, pc_load_o}, 0);
    @(negedge clk);
    chk("R5 busy second", {31'd0, busy_o}, 1);
    chk("R5 done second", {31'd0, done_o}, 1);
    chk("R6 strobe", {31'd0, pc_load_o}, {31'd0, exp_t});
    chk("R6 pc_next", {16'd0, pc_next_o}, {16'd0, exp_t ? exp_target(pc, off) : pc});
    @(negedge clk);
    chk("R5 slot ends", {30'd0, busy_o, done_o}, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; pc_i = '0;
    {fz, fc, fn, fv} = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy_o}, 0);
    chk("R9 reset done", {31'd0, done_o}, 0);
    chk("R9 reset strobe", {31'd0, pc_load_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3: all opcode classes, conditions and flag combinations.
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 16; f++) begin
          instr_i = {3'(op), 3'(c), 10'((op * 37 + c * 101 + f * 13) % 1024)};
          {fn, fv, fc, fz} = 4'(f);
          #0.1;
          chk("R1 is_jump", {31'd0, is_jump_o}, {31'd0, op == 1});
          chk("R2/R3 taken", {31'd0, taken_o},
              {31'd0, (op == 1) && exp_cond(c, f[0], f[1], f[3], f[2])});
        end

    // R4: every offset with several program counter values.
    for (int p = 0; p < 5; p++) begin
      logic [15:0] pcv;
      case (p)
        0: pcv = 16'h0000;
        1: pcv = 16'h0001;
        2: pcv = 16'hFFFE;
        3: pcv = 16'h8000;
        default: pcv = 16'h1235;
      endcase
      for (int o = 0; o < 1024; o++) begin
        instr_i = {3'b001, 3'b111, 10'(o)};
        pc_i = pcv;
        #0.1;
        chk("R4 target", {16'd0, target_o}, {16'd0, exp_target(pcv, o)});
      end
    end

    // R5 R6: slots with each condition, taken and not taken.
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 5)
        run_slot(c, (c * 211 + f * 67) % 1024, 16'(16'h4000 + c * 6 + f * 2), 4'(f));
    run_slot(7, 10'h200, 16'h0100, 4'h0);  // most negative offset, wraps below zero
    run_slot(7, 10'h1FF, 16'hFFF0, 4'h0);  // largest positive offset, wraps past top

    // R7: non-branch issue starts nothing.
    for (int op = 0; op < 8; op++) begin
      if (op == 1) continue;
      @(negedge clk);
      instr_i = {3'(op), 13'h1FFF};
      issue_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
      chk("R7 no busy", {31'd0, busy_o}, 0);
      @(negedge clk);
      chk("R7 no done/strobe", {30'd0, done_o, pc_load_o}, 0);
    end

    // R8: issue during slot ignored.
    @(negedge clk);
    instr_i = {3'b001, 3'b111, 10'd4};
    pc_i = 16'h2000;
    issue_i = 1'b1;
    @(negedge clk);
    instr_i = {3'b001, 3'b111, 10'd100};
    pc_i = 16'h3000;
    @(negedge clk);
    issue_i = 1'b0;
    chk("R8 first slot result", {16'd0, pc_next_o}, 32'h2008);
    chk("R8 strobe", {31'd0, pc_load_o}, 1);
    @(negedge clk);
    chk("R8 no extra slot", {30'd0, busy_o, done_o}, 0);

    // R9: reset in the middle of a slot clears it.
    run_slot(7, 3, 16'h0010, 4'h0);
    @(negedge clk);
    instr_i = {3'b001, 3'b111, 10'd1};
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9 reset mid-slot", {29'd0, busy_o, done_o, pc_load_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule